// File: doc/BRIEF.md
# Dual-Bus Fault Capture Status Register

This block watches two independent shared system buses, named north and south. For each bus it tracks the identifier of the master that most recently drove a transfer and the slave that most recently answered it. It also tracks the port number of the last requester on a multi-port memory interface. All of this is visible through a single 32-bit status word.

When a bus raises its error strobe, that bus's master and slave fields freeze and a sticky fault flag for that bus is set. The frozen fields stay in place until software writes a one to the flag. If the faulting access decoded to no slave, the slave field holds the reserved code 0xF. Each bus accepts only its own valid device numbers in each field, so a stray identifier cannot corrupt the record. The register port is one write strobe with its data word. The read data is the status word, valid one cycle after the inputs it reflects.

Top module: `busfault_capture`

## Requirements
- R1: After reset the whole status word reads 0x0000_0000.
- R2: The status word layout is: north master [3:0], south master [7:4], north slave [11:8], south slave [15:12], memory port [19:16], north fault flag bit 30, south fault flag bit 31. Bits 29:20 always read zero. Writes never change bits 29:0.
- R3: While a bus's fault flag is clear, a transfer-valid cycle on that bus loads its master and slave IDs into that bus's fields. The new values are readable in the next cycle.
- R4: A field loads only IDs from its own set: north masters {0,1,2}, north slaves {3,4}, south masters {0,1,2,3,4}, south slaves {1,3,4,5}. An ID outside the set leaves that field unchanged.
- R5: An error strobe sets the bus's fault flag in the next cycle. If a transfer is valid in the same cycle, that transfer's IDs are captured. If no transfer is valid, the fields keep their last tracked values.
- R6: While a bus's fault flag is set and not being cleared, neither transfers nor further errors on that bus change its master or slave field.
- R7: An error with the decode-miss input high loads 0xF into that bus's slave field. A decode miss without an error is ignored.
- R8: Writing a one to bit 30 clears the north flag, and writing a one to bit 31 clears the south flag. Writing a zero leaves the flag unchanged. The two flags are cleared independently.
- R9: When a clearing write and a new error arrive on the same bus in the same cycle, the flag stays set and the fields capture the new error's IDs.
- R10: Every memory-access strobe loads its port ID into bits 19:16, whatever the state of either fault flag.
- R11: A fault on one bus does not stop the other bus from tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| n_xfer_vld | input | 1 | North bus transfer valid |
| n_mst_id | input | 4 | North bus master device number |
| n_slv_id | input | 4 | North bus slave device number |
| n_err | input | 1 | North bus error strobe |
| n_miss | input | 1 | North bus address decode miss |
| s_xfer_vld | input | 1 | South bus transfer valid |
| s_mst_id | input | 4 | South bus master device number |
| s_slv_id | input | 4 | South bus slave device number |
| s_err | input | 1 | South bus error strobe |
| s_miss | input | 1 | South bus address decode miss |
| mem_acc_vld | input | 1 | Memory interface access strobe |
| mem_port_id | input | 4 | Requesting memory port number |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_wdata | input | 32 | Status register write data |
| reg_rdata | output | 32 | Status register read data |

## Verification
The bench targets four cases. An error strobe arriving while the flag is already set must not recapture, or a later fault would overwrite the first one. A clearing write in the same cycle as a new error must leave the flag set with the new IDs, or that fault would be lost. An error with no transfer must keep the last tracked IDs rather than load stale input values. The bench also sends out-of-set IDs and decode misses without an error. A design with missing ID filtering or loose miss handling would show 0xF or foreign device numbers in a field.

// File: rtl/busfault_pkg.sv
package busfault_pkg;
  localparam int ID_W      = 4;
  localparam int NUM_IDS   = 1 << ID_W;
  localparam int WORD_W    = 32;
  localparam int NUM_BUS   = 2;
  localparam int BUS_N     = 0;
  localparam int BUS_S     = 1;

  localparam int N_MST_LSB = 0;
  localparam int S_MST_LSB = N_MST_LSB + ID_W;
  localparam int N_SLV_LSB = S_MST_LSB + ID_W;
  localparam int S_SLV_LSB = N_SLV_LSB + ID_W;
  localparam int MEM_LSB   = S_SLV_LSB + ID_W;
  localparam int N_FLG_BIT = WORD_W - 2;
  localparam int S_FLG_BIT = WORD_W - 1;

  typedef logic [ID_W-1:0]    dev_id_t;
  typedef logic [NUM_IDS-1:0] id_set_t;

  localparam dev_id_t MISS_CODE = '1;

  function automatic logic id_in_set(id_set_t set, dev_id_t id);
    return set[id];
  endfunction

  function automatic int flag_bit(int bus);
    return (bus == BUS_N) ? N_FLG_BIT : S_FLG_BIT;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
    logic flg_n, logic flg_s, dev_id_t mem,
    dev_id_t mst_n, dev_id_t mst_s, dev_id_t slv_n, dev_id_t slv_s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[N_MST_LSB +: ID_W] = mst_n;
    w[S_MST_LSB +: ID_W] = mst_s;
    w[N_SLV_LSB +: ID_W] = slv_n;
    w[S_SLV_LSB +: ID_W] = slv_s;
    w[MEM_LSB   +: ID_W] = mem;
    w[N_FLG_BIT]         = flg_n;
    w[S_FLG_BIT]         = flg_s;
    return w;
  endfunction
endpackage

// File: rtl/busfault_lane.sv
module busfault_lane
  import busfault_pkg::*;
#(
  parameter id_set_t MST_SET = '1,
  parameter id_set_t SLV_SET = '1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    xfer_vld,
  input  dev_id_t mst_id,
  input  dev_id_t slv_id,
  input  logic    err,
  input  logic    miss,
  input  logic    clr_req,
  output logic    flag_o,
  output dev_id_t mst_o,
  output dev_id_t slv_o,
  output logic    capture_o,
  output logic    frozen_o
);
  logic    flag_q, flag_d;
  dev_id_t mst_q, mst_d, slv_q, slv_d;
  logic    track_ok, cap_ok, capture, load;

  always_comb begin
    track_ok = ~flag_q;
    cap_ok   = ~flag_q | clr_req;
    capture  = err & cap_ok;
    load     = capture | (xfer_vld & track_ok);

    mst_d = mst_q;
    if (load && xfer_vld && id_in_set(MST_SET, mst_id))
      mst_d = mst_id;

    slv_d = slv_q;
    if (capture && miss)
      slv_d = MISS_CODE;
    else if (load && xfer_vld && id_in_set(SLV_SET, slv_id))
      slv_d = slv_id;

    flag_d = err | (flag_q & ~clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mst_q  <= '0;
      slv_q  <= '0;
    end else begin
      flag_q <= flag_d;
      mst_q  <= mst_d;
      slv_q  <= slv_d;
    end
  end

  assign flag_o    = flag_q;
  assign mst_o     = mst_q;
  assign slv_o     = slv_q;
  assign capture_o = capture;
  assign frozen_o  = flag_q & ~clr_req;
endmodule

// File: rtl/busfault_memport.sv
module busfault_memport
  import busfault_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    acc_vld,
  input  dev_id_t port_id,
  output dev_id_t port_o
);
  dev_id_t port_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_q <= '0;
    else if (acc_vld) port_q <= port_id;
  end

  assign port_o = port_q;
endmodule

// File: rtl/busfault_regs.sv
module busfault_regs
  import busfault_pkg::*;
(
  input  logic              wr_en,
  input  logic [NUM_BUS-1:0] wr_flag_bits,
  input  logic [NUM_BUS-1:0] flags,
  input  dev_id_t           mst [NUM_BUS],
  input  dev_id_t           slv [NUM_BUS],
  input  dev_id_t           mem_port,
  output logic [NUM_BUS-1:0] clr_req,
  output logic [WORD_W-1:0] rdata
);
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_clr
    assign clr_req[b] = wr_en & wr_flag_bits[b];
  end

  assign rdata = pack_status(flags[BUS_N], flags[BUS_S], mem_port,
                             mst[BUS_N], mst[BUS_S], slv[BUS_N], slv[BUS_S]);
endmodule

// File: rtl/busfault_capture.sv
module busfault_capture
  import busfault_pkg::*;
#(
  parameter id_set_t N_MST_SET = 16'h0007,
  parameter id_set_t N_SLV_SET = 16'h0018,
  parameter id_set_t S_MST_SET = 16'h001F,
  parameter id_set_t S_SLV_SET = 16'h003A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              n_xfer_vld,
  input  logic [ID_W-1:0]   n_mst_id,
  input  logic [ID_W-1:0]   n_slv_id,
  input  logic              n_err,
  input  logic              n_miss,
  input  logic              s_xfer_vld,
  input  logic [ID_W-1:0]   s_mst_id,
  input  logic [ID_W-1:0]   s_slv_id,
  input  logic              s_err,
  input  logic              s_miss,
  input  logic              mem_acc_vld,
  input  logic [ID_W-1:0]   mem_port_id,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata
);
  logic [NUM_BUS-1:0] xfer_a, err_a, miss_a, clr_a, flag_a, cap_a, frz_a;
  logic [NUM_BUS-1:0] wr_flag_bits;
  dev_id_t            mid_a [NUM_BUS];
  dev_id_t            sid_a [NUM_BUS];
  dev_id_t            mst_a [NUM_BUS];
  dev_id_t            slv_a [NUM_BUS];
  dev_id_t            mem_port_q;

  assign xfer_a = {s_xfer_vld, n_xfer_vld};
  assign err_a  = {s_err, n_err};
  assign miss_a = {s_miss, n_miss};
  assign mid_a[BUS_N] = n_mst_id;
  assign mid_a[BUS_S] = s_mst_id;
  assign sid_a[BUS_N] = n_slv_id;
  assign sid_a[BUS_S] = s_slv_id;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_lane
    localparam id_set_t MSET = (b == BUS_N) ? N_MST_SET : S_MST_SET;
    localparam id_set_t SSET = (b == BUS_N) ? N_SLV_SET : S_SLV_SET;

    assign wr_flag_bits[b] = reg_wdata[flag_bit(b)];

    busfault_lane #(.MST_SET(MSET), .SLV_SET(SSET)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer_vld  (xfer_a[b]),
      .mst_id    (mid_a[b]),
      .slv_id    (sid_a[b]),
      .err       (err_a[b]),
      .miss      (miss_a[b]),
      .clr_req   (clr_a[b]),
      .flag_o    (flag_a[b]),
      .mst_o     (mst_a[b]),
      .slv_o     (slv_a[b]),
      .capture_o (cap_a[b]),
      .frozen_o  (frz_a[b])
    );
  end

  busfault_memport u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_vld (mem_acc_vld),
    .port_id (mem_port_id),
    .port_o  (mem_port_q)
  );

  busfault_regs u_regs (
    .wr_en        (reg_wr_en),
    .wr_flag_bits (wr_flag_bits),
    .flags        (flag_a),
    .mst          (mst_a),
    .slv          (slv_a),
    .mem_port     (mem_port_q),
    .clr_req      (clr_a),
    .rdata        (reg_rdata)
  );

  // Named internal events for the checker
  logic n_capture_evt, s_capture_evt, n_frozen, s_frozen;
  assign n_capture_evt = cap_a[BUS_N];
  assign s_capture_evt = cap_a[BUS_S];
  assign n_frozen      = frz_a[BUS_N];
  assign s_frozen      = frz_a[BUS_S];
endmodule

// File: rtl/busfault_capture_sva.sv
module busfault_capture_sva
  import busfault_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              n_err,
  input logic              s_err,
  input logic              n_miss,
  input logic              s_miss,
  input logic              mem_acc_vld,
  input logic [ID_W-1:0]   mem_port_id,
  input logic              reg_wr_en,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              n_capture_evt,
  input logic              s_capture_evt
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[MEM_LSB+ID_W +: (N_FLG_BIT-MEM_LSB-ID_W)] == '0);

  p_north_err_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    n_err |=> reg_rdata[N_FLG_BIT]);
  p_south_err_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_err |=> reg_rdata[S_FLG_BIT]);

  p_north_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[N_FLG_BIT] && !(reg_wr_en && reg_wdata[N_FLG_BIT])
    |=> $stable(reg_rdata[N_MST_LSB +: ID_W]) && $stable(reg_rdata[N_SLV_LSB +: ID_W]));
  p_south_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[S_FLG_BIT] && !(reg_wr_en && reg_wdata[S_FLG_BIT])
    |=> $stable(reg_rdata[S_MST_LSB +: ID_W]) && $stable(reg_rdata[S_SLV_LSB +: ID_W]));

  p_north_miss_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    n_capture_evt && n_miss |=> reg_rdata[N_SLV_LSB +: ID_W] == MISS_CODE);
  p_south_miss_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_capture_evt && s_miss |=> reg_rdata[S_SLV_LSB +: ID_W] == MISS_CODE);

  p_north_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[N_FLG_BIT] && !(reg_wr_en && reg_wdata[N_FLG_BIT]) |=> reg_rdata[N_FLG_BIT]);
  p_south_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[S_FLG_BIT] && !(reg_wr_en && reg_wdata[S_FLG_BIT]) |=> reg_rdata[S_FLG_BIT]);

  p_north_capture_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    n_capture_evt |-> (!reg_rdata[N_FLG_BIT] || (reg_wr_en && reg_wdata[N_FLG_BIT])));
  p_south_capture_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_capture_evt |-> (!reg_rdata[S_FLG_BIT] || (reg_wr_en && reg_wdata[S_FLG_BIT])));

  p_mem_port_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_acc_vld |=> reg_rdata[MEM_LSB +: ID_W] == $past(mem_port_id));
endmodule

bind busfault_capture busfault_capture_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .n_err         (n_err),
  .s_err         (s_err),
  .n_miss        (n_miss),
  .s_miss        (s_miss),
  .mem_acc_vld   (mem_acc_vld),
  .mem_port_id   (mem_port_id),
  .reg_wr_en     (reg_wr_en),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .n_capture_evt (n_capture_evt),
  .s_capture_evt (s_capture_evt)
);

// File: tb/busfault_capture_tb.sv
module busfault_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        n_xfer_vld, n_err, n_miss, s_xfer_vld, s_err, s_miss;
  logic [3:0]  n_mst_id, n_slv_id, s_mst_id, s_slv_id, mem_port_id;
  logic        mem_acc_vld, reg_wr_en;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // expected model state
  logic [3:0] e_nm, e_sm, e_ns, e_ss, e_mp;
  logic       e_nf, e_sf;

  always #(CLK_PERIOD/2) clk = ~clk;

  busfault_capture dut_i (
    .clk(clk), .rst_n(rst_n),
    .n_xfer_vld(n_xfer_vld), .n_mst_id(n_mst_id), .n_slv_id(n_slv_id),
    .n_err(n_err), .n_miss(n_miss),
    .s_xfer_vld(s_xfer_vld), .s_mst_id(s_mst_id), .s_slv_id(s_slv_id),
    .s_err(s_err), .s_miss(s_miss),
    .mem_acc_vld(mem_acc_vld), .mem_port_id(mem_port_id),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] expect_word();
    return {e_sf, e_nf, 10'd0, e_mp, e_ss, e_ns, e_sm, e_nm};
  endfunction

  task automatic idle_inputs();
    n_xfer_vld = 0; n_err = 0; n_miss = 0; n_mst_id = 0; n_slv_id = 0;
    s_xfer_vld = 0; s_err = 0; s_miss = 0; s_mst_id = 0; s_slv_id = 0;
    mem_acc_vld = 0; mem_port_id = 0; reg_wr_en = 0; reg_wdata = 0;
  endtask

  // Inputs are set before tick; tick applies them for one edge and samples after it.
  task automatic tick();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic check(string req, string what);
    checks++;
    if (reg_rdata !== expect_word()) begin
      errors++;
      $display("FAIL %s %s: got %08h expected %08h", req, what, reg_rdata, expect_word());
    end
  endtask

  task automatic north_xfer(logic [3:0] m, logic [3:0] s);
    n_xfer_vld = 1; n_mst_id = m; n_slv_id = s;
  endtask

  task automatic south_xfer(logic [3:0] m, logic [3:0] s);
    s_xfer_vld = 1; s_mst_id = m; s_slv_id = s;
  endtask

  task automatic t_reset();
    e_nm = 0; e_sm = 0; e_ns = 0; e_ss = 0; e_mp = 0; e_nf = 0; e_sf = 0;
    check("R1", "reset word");
  endtask

  task automatic t_track();
    north_xfer(4'd1, 4'd3); south_xfer(4'd4, 4'd5); tick();
    e_nm = 1; e_ns = 3; e_sm = 4; e_ss = 5;
    check("R3", "both buses tracked");
    reg_wr_en = 1; reg_wdata = 32'hFFFF_FFFF; tick();
    check("R2", "all-ones write with flags clear");
  endtask

  task automatic t_filter();
    north_xfer(4'd5, 4'd1); south_xfer(4'd5, 4'd2); tick();
    check("R4", "out-of-set IDs ignored");
    north_xfer(4'd0, 4'd4); south_xfer(4'd0, 4'd1); tick();
    e_nm = 0; e_ns = 4; e_sm = 0; e_ss = 1;
    check("R4", "in-set IDs loaded");
  endtask

  task automatic t_error_freeze();
    n_err = 1; tick();
    e_nf = 1;
    check("R5", "error alone keeps last IDs");
    north_xfer(4'd2, 4'd3); tick();
    check("R6", "transfer while frozen");
    north_xfer(4'd1, 4'd3); n_err = 1; tick();
    check("R6", "second error while frozen");
    south_xfer(4'd3, 4'd3); tick();
    e_sm = 3; e_ss = 3;
    check("R11", "south tracks while north frozen");
  endtask

  task automatic t_w1c();
    reg_wr_en = 1; reg_wdata = 32'h0; tick();
    check("R8", "write zero keeps flag");
    reg_wr_en = 1; reg_wdata = 32'h8000_0000; tick();
    check("R8", "south clear leaves north flag");
    reg_wr_en = 1; reg_wdata = 32'h4000_0000; tick();
    e_nf = 0;
    check("R8", "north flag cleared");
    north_xfer(4'd2, 4'd3); tick();
    e_nm = 2; e_ns = 3;
    check("R3", "tracking resumes after clear");
  endtask

  task automatic t_coincide_miss();
    north_xfer(4'd1, 4'd4); n_err = 1; tick();
    e_nf = 1; e_nm = 1; e_ns = 4;
    check("R5", "coincident transfer captured");
    south_xfer(4'd2, 4'd5); s_miss = 1; tick();
    e_sm = 2; e_ss = 5;
    check("R7", "miss without error ignored");
    south_xfer(4'd4, 4'd1); s_err = 1; s_miss = 1; tick();
    e_sf = 1; e_sm = 4; e_ss = 4'hF;
    check("R7", "decode miss code captured");
  endtask

  task automatic t_clear_vs_error();
    reg_wr_en = 1; reg_wdata = 32'h8000_0000;
    south_xfer(4'd1, 4'd3); s_err = 1; tick();
    e_sm = 1; e_ss = 3;
    check("R9", "error wins over clear");
    reg_wr_en = 1; reg_wdata = 32'hC000_0000; tick();
    e_nf = 0; e_sf = 0;
    check("R8", "both flags cleared together");
  endtask

  task automatic t_mem();
    n_err = 1; mem_acc_vld = 1; mem_port_id = 4'd9; tick();
    e_nf = 1; e_mp = 9;
    check("R10", "memory port with error");
    mem_acc_vld = 1; mem_port_id = 4'hA; north_xfer(4'd0, 4'd3); tick();
    e_mp = 4'hA;
    check("R10", "memory port while north frozen");
    tick();
    check("R10", "memory port holds when idle");
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_track();
    t_filter();
    t_error_freeze();
    t_w1c();
    t_coincide_miss();
    t_clear_vs_error();
    t_mem();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule